// File: doc/BRIEF.md
# DMA Segment Length Calculator

This unit plans one piece of a long 64-bit-word SPI transfer that is fed by DMA. Each time it is strobed, it takes the number of words still outstanding and returns three values. The first is the length of the next SPI segment. The second is the DMA burst length to use inside that segment. The third is the number of bursts that segment takes. It also returns the count that will be left once the segment is done.

The choice follows a fixed order of cases. A remainder that fits in the FIFO is sent whole, as a single burst. A remainder at or beyond the largest segment (eight words times the burst-count limit) is capped at that limit. The one value just above the limit is given a shorter segment. Otherwise the largest burst length from eight down to two that divides the remainder is used, and the whole remainder is sent. When no such length divides it, the segment is cut to a multiple of eight. No case ever leaves exactly one word behind, because a burst of one word cannot be triggered.

A controller strobes `start` with the current remainder. It takes the result one cycle later. It then strobes again with `rest_out` until the rest reaches zero.

Top module: `seglen_calc`

## Requirements
- R1: A remainder from 2 up to FIFO_DEPTH (default 16) gives segment = remainder, burst length = remainder, burst count = 1, rest = 0.
- R2: A remainder of 0 or 1 raises `err` and gives segment 0, burst length 0 and burst count 0; `rest_out` equals the remainder.
- R3: A remainder of exactly MAX_SEG+1 (MAX_SEG = 8 × MAX_BURSTS, default 524280) gives segment MAX_SEG−8, burst length 8 and burst count MAX_BURSTS−1.
- R4: Any other remainder of at least MAX_SEG gives segment MAX_SEG, burst length 8 and burst count MAX_BURSTS.
- R5: Otherwise, when some length among 8, 7, …, 2 divides the remainder, the largest such length is the burst length, the segment is the whole remainder and the burst count is the quotient.
- R6: When no length from 2 to 8 divides the remainder, the burst length is 8 and the segment is the remainder minus (remainder mod 8).
- R7: In the case of R6, if the remainder mod 8 is 1, a further 8 words are taken off the segment, so that `rest_out` is never 1.
- R8: For every non-error result, burst length × burst count equals the segment, and segment + `rest_out` equals the remainder that was sampled.
- R9: `valid` is high exactly in the cycle after a cycle with `start` high. The result registers change only on `start`, and they hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sample `remain` and compute a new result |
| remain | input | REM_W | Words still to transfer |
| valid | output | 1 | Result registered from the previous cycle's start |
| err | output | 1 | Remainder too small to form a segment |
| seg_len | output | REM_W | Words in the next segment |
| burst_len | output | BL_W | DMA burst length for the segment |
| burst_cnt | output | CNT_W | Number of bursts in the segment |
| rest_out | output | REM_W | Words left after the segment |

## Verification
Two things can happen in the same cycle: one result is being presented through `valid`, and the next remainder is being sampled on `start`. The bench provokes this with back-to-back strobes. The remainders are chosen from different cases, a divisor hit followed by a trimmed segment. It judges that `valid` stays high across both cycles, and that each cycle shows exactly the result of the strobe just before it, with no mixing of fields. A second overlap is the boundary between the cap cases and the divisor search. It is judged by remainders just below, at and just above MAX_SEG. One of these is below the cap but divisible by 7, and it needs a burst count wider than MAX_BURSTS allows.

// File: rtl/seglen_pkg.sv
package seglen_pkg;
    localparam int DEF_BLEN = 8;
    localparam int MIN_BLEN = 2;

    typedef enum logic [2:0] {
        SEG_ERR,
        SEG_SMALL,
        SEG_WRAP,
        SEG_MAX,
        SEG_DIV,
        SEG_TRIM
    } seg_kind_e;
endpackage

// File: rtl/seglen_divscan.sv
module seglen_divscan #(
    parameter int REM_W = 32,
    parameter int CNT_W = 20
) (
    input  logic [REM_W-1:0] remain,
    output logic             hit,
    output logic [3:0]       blen,
    output logic [CNT_W-1:0] quot
);
    import seglen_pkg::*;

    logic             ok_w [DEF_BLEN:MIN_BLEN];
    logic [CNT_W-1:0] q_w  [DEF_BLEN:MIN_BLEN];

    // One constant-divisor test per candidate burst length
    for (genvar k = MIN_BLEN; k <= DEF_BLEN; k++) begin : g_cand
        assign ok_w[k] = (remain % REM_W'(k)) == '0;
        assign q_w[k]  = CNT_W'(remain / REM_W'(k));
    end

    // Ascending scan: the last (largest) divisor found wins
    always_comb begin
        hit  = 1'b0;
        blen = '0;
        quot = '0;
        for (int k = MIN_BLEN; k <= DEF_BLEN; k++) begin
            if (ok_w[k]) begin
                hit  = 1'b1;
                blen = 4'(k);
                quot = q_w[k];
            end
        end
    end
endmodule

// File: rtl/seglen_classify.sv
module seglen_classify #(
    parameter int REM_W      = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int MAX_SEG    = 524280
) (
    input  logic [REM_W-1:0]      remain,
    input  logic                  div_hit,
    output seglen_pkg::seg_kind_e kind
);
    import seglen_pkg::*;

    localparam logic [REM_W-1:0] FIFO_V = REM_W'(FIFO_DEPTH);
    localparam logic [REM_W-1:0] MAX_V  = REM_W'(MAX_SEG);

    // Priority order matters: the wrap case must be tested before the cap
    always_comb begin
        if (remain <= REM_W'(1))        kind = SEG_ERR;
        else if (remain <= FIFO_V)      kind = SEG_SMALL;
        else if (remain == MAX_V + 1'b1) kind = SEG_WRAP;
        else if (remain >= MAX_V)       kind = SEG_MAX;
        else if (div_hit)               kind = SEG_DIV;
        else                            kind = SEG_TRIM;
    end
endmodule

// File: rtl/seglen_calc.sv
module seglen_calc #(
    parameter int REM_W      = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int MAX_BURSTS = 65535,
    localparam int MAX_SEG   = seglen_pkg::DEF_BLEN * MAX_BURSTS,
    localparam int CNT_W     = $clog2(MAX_SEG + 1),
    localparam int BL_W      = ($clog2(FIFO_DEPTH + 1) > 4) ? $clog2(FIFO_DEPTH + 1) : 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REM_W-1:0] remain,
    output logic             valid,
    output logic             err,
    output logic [REM_W-1:0] seg_len,
    output logic [BL_W-1:0]  burst_len,
    output logic [CNT_W-1:0] burst_cnt,
    output logic [REM_W-1:0] rest_out
);
    import seglen_pkg::*;

    localparam int DEF_SH = $clog2(DEF_BLEN);
    localparam logic [REM_W-1:0] MAX_V = REM_W'(MAX_SEG);

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [REM_W-1:0] seg;
        logic [BL_W-1:0]  blen;
        logic [CNT_W-1:0] cnt;
        logic [REM_W-1:0] rest;
    } res_t;

    res_t res_d, res_q;

    logic             scan_hit;
    logic [3:0]       scan_blen;
    logic [CNT_W-1:0] scan_quot;
    seg_kind_e        kind;
    logic [REM_W-1:0] tail;

    seglen_divscan #(.REM_W(REM_W), .CNT_W(CNT_W)) u_scan (
        .remain (remain),
        .hit    (scan_hit),
        .blen   (scan_blen),
        .quot   (scan_quot)
    );

    seglen_classify #(.REM_W(REM_W), .FIFO_DEPTH(FIFO_DEPTH), .MAX_SEG(MAX_SEG)) u_cls (
        .remain  (remain),
        .div_hit (scan_hit),
        .kind    (kind)
    );

    assign tail = remain & REM_W'(DEF_BLEN - 1);

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (start) begin
            res_d.valid = 1'b1;
            res_d.err   = 1'b0;
            res_d.seg   = '0;
            res_d.blen  = BL_W'(DEF_BLEN);
            res_d.cnt   = '0;
            unique case (kind)
                SEG_ERR: begin
                    res_d.err  = 1'b1;
                    res_d.blen = '0;
                end
                SEG_SMALL: begin
                    res_d.seg  = remain;
                    res_d.blen = BL_W'(remain);
                    res_d.cnt  = CNT_W'(1);
                end
                SEG_WRAP: begin
                    res_d.seg = MAX_V - REM_W'(DEF_BLEN);
                    res_d.cnt = CNT_W'(MAX_BURSTS - 1);
                end
                SEG_MAX: begin
                    res_d.seg = MAX_V;
                    res_d.cnt = CNT_W'(MAX_BURSTS);
                end
                SEG_DIV: begin
                    res_d.seg  = remain;
                    res_d.blen = BL_W'(scan_blen);
                    res_d.cnt  = scan_quot;
                end
                default: begin
                    res_d.seg = remain - tail
                              - ((tail == REM_W'(1)) ? REM_W'(DEF_BLEN) : '0);
                    res_d.cnt = CNT_W'(res_d.seg >> DEF_SH);
                end
            endcase
            res_d.rest = remain - res_d.seg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign valid     = res_q.valid;
    assign err       = res_q.err;
    assign seg_len   = res_q.seg;
    assign burst_len = res_q.blen;
    assign burst_cnt = res_q.cnt;
    assign rest_out  = res_q.rest;

    p_valid_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    p_valid_only_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(start));
    p_hold_without_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(seg_len) && $stable(burst_cnt) && $stable(rest_out)));
    p_err_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && err) |-> (seg_len == '0 && burst_cnt == '0));
    p_sum_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !err) |-> (seg_len + rest_out == $past(remain)));
    p_product_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !err) |-> (REM_W'(burst_len) * REM_W'(burst_cnt) == seg_len));
    p_no_unit_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !err) |-> (rest_out != REM_W'(1)));
endmodule

// File: tb/seglen_calc_test.sv
module seglen_calc_test;
    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] remain = '0;
    logic        valid, err;
    logic [31:0] seg_len, rest_out;
    logic [4:0]  burst_len;
    logic [19:0] burst_cnt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    seglen_calc uut (
        .clk(clk), .rst_n(rst_n), .start(start), .remain(remain),
        .valid(valid), .err(err), .seg_len(seg_len), .burst_len(burst_len),
        .burst_cnt(burst_cnt), .rest_out(rest_out)
    );

    // remain, err, seg, blen, cnt, rest, requirement tag
    localparam int unsigned V_REM [NV] = '{0, 1, 2, 16, 24, 21, 18, 25, 22, 33,
        19, 23, 17, 41, 524281, 524280, 1000000, 524279, 524278};
    localparam int unsigned V_ERR [NV] = '{1, 1, 0, 0, 0, 0, 0, 0, 0, 0,
        0, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam int unsigned V_SEG [NV] = '{0, 0, 2, 16, 24, 21, 18, 25, 22, 33,
        16, 16, 8, 32, 524272, 524280, 524280, 524279, 524278};
    localparam int unsigned V_BL  [NV] = '{0, 0, 2, 16, 8, 7, 6, 5, 2, 3,
        8, 8, 8, 8, 8, 8, 8, 7, 2};
    localparam int unsigned V_CNT [NV] = '{0, 0, 1, 1, 3, 3, 3, 5, 11, 11,
        2, 2, 1, 4, 65534, 65535, 65535, 74897, 262139};
    localparam int unsigned V_RST [NV] = '{0, 1, 0, 0, 0, 0, 0, 0, 0, 0,
        3, 7, 9, 9, 9, 0, 475720, 0, 0};
    localparam string V_TAG [NV] = '{"R2", "R2", "R1", "R1", "R5", "R5", "R5", "R5",
        "R5", "R5", "R6", "R6", "R7", "R7", "R3", "R4", "R4", "R5", "R5"};

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_result(input int i);
        chk(V_TAG[i], "valid", valid, 1);
        chk(V_TAG[i], "err", err, V_ERR[i]);
        chk(V_TAG[i], "seg_len", seg_len, V_SEG[i]);
        chk(V_TAG[i], "burst_len", burst_len, V_BL[i]);
        chk(V_TAG[i], "burst_cnt", burst_cnt, V_CNT[i]);
        chk(V_TAG[i], "rest_out", rest_out, V_RST[i]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk("R9", "reset valid", valid, 0);
        chk("R9", "reset seg_len", seg_len, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "idle valid", valid, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            remain = V_REM[i];
            start  = 1'b1;
            @(negedge clk);
            start  = 1'b0;
            remain = 32'hFFFF_FFF0;
            chk_result(i);
        end

        // R9: no start -> valid drops, result held even though remain changes
        @(negedge clk);
        chk("R9", "valid low", valid, 0);
        chk("R9", "held seg_len", seg_len, V_SEG[NV-1]);
        chk("R9", "held burst_cnt", burst_cnt, V_CNT[NV-1]);

        // R9 / R8: back-to-back strobes, divisor hit (idx 5) then trim (idx 11)
        remain = V_REM[5];
        start  = 1'b1;
        @(negedge clk);
        remain = V_REM[11];
        chk_result(5);
        @(negedge clk);
        start  = 1'b0;
        chk_result(11);
        @(negedge clk);
        chk("R9", "valid after pair", valid, 0);

        // reset mid-result clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", "reset clears valid", valid, 0);
        chk("R9", "reset clears rest", rest_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule